// File: doc/BRIEF.md
# Runs and Long-Run Randomness Test Unit

This block checks a serial stream of random bits for two statistical weaknesses at once. It watches the length of each run of identical bits. At the end of a block it reports whether the number of runs of each length and polarity is plausible for an unbiased source, and whether any single run became suspiciously long. Bits arrive with a valid strobe, at up to one bit per clock. A one-cycle `synch` pulse, issued by the surrounding logic after the last bit of a 20,000-bit block, closes the block.

Internally a state machine tracks the polarity of the current run and its length, up to a ceiling of 26. When a run ends, it is tallied into one of twelve counters in the same clock. There are six length bins, lengths 1 to 5 and 6-or-longer, for each polarity. On `synch` the run still open is tallied too. In the following cycle all twelve counts are compared with fixed pass intervals. A cycle later the verdicts appear together with a one-cycle `ready` pulse. The counters and the long-run flag then clear, so the next block starts fresh.

Top module: `runs_test_unit`

## Requirements
- R1: While reset is asserted and after its release, `ready`, `runs_pass`, `long_pass` and `all_pass` are 0 until the first report.
- R2: A run ends when a valid bit of the other polarity arrives. The ended run of length 1 to 5 is tallied in the counter for its own polarity and length, and the new bit starts a run of length 1.
- R3: A run of 6 or more bits is tallied in the 6-or-longer bin of its polarity.
- R4: The run that is still open when `synch` is sampled is tallied before the comparison.
- R5: `long_pass` is 0 for a block that contained a run of 26 or more equal bits of either polarity, and 1 when the longest run is 25 or shorter. A run longer than 26 keeps the failure.
- R6: `runs_pass` is 1 only when every one of the twelve counts lies inside its inclusive interval. The intervals are the same for zeros and ones: length 1: 2315..2685, length 2: 1114..1386, length 3: 527..723, length 4: 240..384, length 5: 103..209, length 6 or more: 103..209.
- R7: `all_pass` equals `runs_pass` AND `long_pass`.
- R8: `synch` is sampled at clock edge k. At edge k+1 the compare step happens. `ready` is high for exactly the one cycle after edge k+1, and the three verdicts are valid then and hold until the next report.
- R9: After a report, all counters and the long-run flag are cleared, so the next block is judged only on its own bits.
- R10: Bits with `bit_vld` low do not affect the run. A valid bit presented in the `synch` cycle or in the compare cycle that follows belongs to no block and is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized to `clk` |
| bit_vld | input | 1 | `bit_in` carries a new random bit this cycle |
| bit_in | input | 1 | Random bit under test |
| synch | input | 1 | One-cycle pulse closing the current block |
| ready | output | 1 | One-cycle pulse: verdicts are valid |
| runs_pass | output | 1 | All twelve run counts inside their intervals |
| long_pass | output | 1 | No run of 26 or more equal bits in the block |
| all_pass | output | 1 | Both tests passed |

## Verification
The bench drives whole blocks whose run counts sit exactly on interval edges, and one count beyond them, for both polarities. A design with an off-by-one or exclusive bound would flip the verdict. Runs of 7, 8 and 12 bits check that long runs fall into the top bin and are not dropped. One block has a count of exactly 103 whose last run is the one open at `synch`, so a design that forgets the open run fails that block. Directed blocks with 25 and 26 equal bits, invalid bits of the other value placed inside a run, and valid bits during the `synch` and compare cycles expose three faults: a long-run threshold that is off by one, a design that treats invalid cycles as data, and a run that leaks across block boundaries.

// File: rtl/runs_pkg.sv
package runs_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_CMP  = 2'd2
  } run_mode_e;

  // Inclusive lower bound of the pass window for length bin b (0 = length 1).
  function automatic int unsigned bin_lo(input int b);
    case (b)
      0:       return 2315;
      1:       return 1114;
      2:       return 527;
      3:       return 240;
      default: return 103;
    endcase
  endfunction

  // Inclusive upper bound of the pass window for length bin b.
  function automatic int unsigned bin_hi(input int b);
    case (b)
      0:       return 2685;
      1:       return 1386;
      2:       return 723;
      3:       return 384;
      default: return 209;
    endcase
  endfunction

endpackage

// File: rtl/runs_fsm.sv
module runs_fsm
  import runs_pkg::*;
#(
  parameter int BINS     = 6,
  parameter int LONG_LEN = 26,
  parameter int LEN_W    = 5,
  parameter int BIN_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             synch,
  output run_mode_e        mode_o,
  output logic             tally_vld_o,
  output logic             tally_pol_o,
  output logic [BIN_W-1:0] tally_bin_o,
  output logic             long_seen_o,
  output logic             clr_o
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(LONG_LEN);
  localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(BINS);

  run_mode_e        mode_q, mode_d;
  logic             pol_q, pol_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             long_q, long_d;
  logic             tally_vld, clr;

  // Next-state logic: the state (polarity, length) is the current run.
  always_comb begin
    mode_d    = mode_q;
    pol_d     = pol_q;
    len_d     = len_q;
    long_d    = long_q;
    tally_vld = 1'b0;
    clr       = 1'b0;
    unique case (mode_q)
      MODE_IDLE: begin
        if (synch) begin
          mode_d = MODE_CMP;
        end else if (bit_vld) begin
          mode_d = MODE_RUN;
          pol_d  = bit_in;
          len_d  = LEN_ONE;
        end
      end
      MODE_RUN: begin
        if (synch) begin
          tally_vld = 1'b1;           // open run closes with the block
          mode_d    = MODE_CMP;
        end else if (bit_vld) begin
          if (bit_in == pol_q) begin
            if (len_q != LEN_MAX) len_d = len_q + LEN_ONE;
            if (len_q == LEN_MAX - LEN_ONE) long_d = 1'b1;
          end else begin
            tally_vld = 1'b1;
            pol_d     = bit_in;
            len_d     = LEN_ONE;
          end
        end
      end
      MODE_CMP: begin
        clr    = 1'b1;
        mode_d = MODE_IDLE;
        long_d = 1'b0;
        len_d  = '0;
      end
      default: mode_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      pol_q  <= 1'b0;
      len_q  <= '0;
      long_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pol_q  <= pol_d;
      len_q  <= len_d;
      long_q <= long_d;
    end
  end

  // Length bin of the run being closed; every length from BINS up shares the top bin.
  always_comb begin
    if (len_q >= LEN_TOP) tally_bin_o = BIN_W'(BINS - 1);
    else                  tally_bin_o = BIN_W'(len_q - LEN_ONE);
  end

  assign mode_o      = mode_q;
  assign tally_vld_o = tally_vld;
  assign tally_pol_o = pol_q;
  assign long_seen_o = long_q;
  assign clr_o       = clr;

  AST_RUN_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN) |-> (len_q >= LEN_ONE && len_q <= LEN_MAX)); // R3

  AST_FLIP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && !synch && bit_vld && bit_in != pol_q)
      |=> (mode_q == MODE_RUN && len_q == LEN_ONE && pol_q == $past(bit_in))); // R2

  AST_LONG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && len_q == LEN_MAX) |-> long_q); // R5

  AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CMP) |=> (mode_q == MODE_IDLE && !long_q)); // R9

  AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && !bit_vld && !synch) |=> ($stable(len_q) && $stable(pol_q))); // R10

endmodule

// File: rtl/runs_tally.sv
module runs_tally #(
  parameter int BINS  = 6,
  parameter int CNT_W = 15,
  parameter int BIN_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tally_vld,
  input  logic                           tally_pol,
  input  logic [BIN_W-1:0]               tally_bin,
  input  logic                           clr,
  output logic [2*BINS-1:0][CNT_W-1:0]   counts
);

  localparam int NCNT  = 2 * BINS;
  localparam int IDX_W = $clog2(NCNT);

  logic [IDX_W-1:0] idx;

  // Zeros occupy slots 0..BINS-1, ones occupy BINS..2*BINS-1.
  always_comb begin
    if (tally_pol) idx = IDX_W'(BINS) + IDX_W'(tally_bin);
    else           idx = IDX_W'(tally_bin);
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = tally_vld && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (clr) begin
        cnt_q <= '0;
      end else if (hit && cnt_q != '1) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end

    assign counts[g] = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (cnt_q != '1)); // R2

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R9
  end

endmodule

// File: rtl/runs_judge.sv
module runs_judge
  import runs_pkg::*;
#(
  parameter int BINS  = 6,
  parameter int CNT_W = 15
) (
  input  logic [2*BINS-1:0][CNT_W-1:0] counts,
  output logic                         runs_ok
);

  always_comb begin
    runs_ok = 1'b1;
    for (int i = 0; i < 2 * BINS; i++) begin
      if (32'(counts[i]) < bin_lo(i % BINS) || 32'(counts[i]) > bin_hi(i % BINS))
        runs_ok = 1'b0;
    end
  end

endmodule

// File: rtl/runs_test_unit.sv
module runs_test_unit
  import runs_pkg::*;
#(
  parameter int BINS     = 6,
  parameter int LONG_LEN = 26,
  parameter int CNT_W    = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic synch,
  output logic ready,
  output logic runs_pass,
  output logic long_pass,
  output logic all_pass
);

  localparam int LEN_W = $clog2(LONG_LEN + 1);
  localparam int BIN_W = $clog2(BINS);

  run_mode_e                    mode;
  logic                         tally_vld, tally_pol, long_seen, clr, runs_ok;
  logic [BIN_W-1:0]             tally_bin;
  logic [2*BINS-1:0][CNT_W-1:0] counts;
  logic                         ready_q, runs_q, long_q;

  runs_fsm #(
    .BINS(BINS), .LONG_LEN(LONG_LEN), .LEN_W(LEN_W), .BIN_W(BIN_W)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .synch(synch),
    .mode_o(mode), .tally_vld_o(tally_vld), .tally_pol_o(tally_pol),
    .tally_bin_o(tally_bin), .long_seen_o(long_seen), .clr_o(clr)
  );

  runs_tally #(.BINS(BINS), .CNT_W(CNT_W), .BIN_W(BIN_W)) i_tally (
    .clk(clk), .rst_n(rst_n), .tally_vld(tally_vld), .tally_pol(tally_pol),
    .tally_bin(tally_bin), .clr(clr), .counts(counts)
  );

  runs_judge #(.BINS(BINS), .CNT_W(CNT_W)) i_judge (
    .counts(counts), .runs_ok(runs_ok)
  );

  // Verdict registers, loaded by the compare step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      runs_q  <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      ready_q <= clr;
      if (clr) begin
        runs_q <= runs_ok;
        long_q <= !long_seen;
      end
    end
  end

  assign ready     = ready_q;
  assign runs_pass = runs_q;
  assign long_pass = long_q;
  assign all_pass  = runs_q & long_q;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q); // R8

  AST_READY_AFTER_SYNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (synch && mode != MODE_CMP) |=> ##1 ready_q); // R8

  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |-> ($stable(runs_q) && $stable(long_q))); // R8

endmodule

// File: tb/test_runs_test_unit.sv
module test_runs_test_unit;

  logic clk = 1'b0;
  logic rst_n, bit_vld, bit_in, synch;
  logic ready, runs_pass, long_pass, all_pass;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;   // 100 MHz

  runs_test_unit i_runs_test_unit (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .synch(synch),
    .ready(ready), .runs_pass(runs_pass), .long_pass(long_pass), .all_pass(all_pass)
  );

  // Row: zero counts bins 1..6, one counts bins 1..6, length used for the
  // top bin, length of an injected long zero run (0 = none), expected runs, expected long.
  localparam int NROWS = 7;
  localparam int TBL [NROWS][16] = '{
    '{2500,1250,625,312,156,156, 2500,1250,625,312,156,156,  7,  0, 1, 1},
    '{2685,1200,600,300,107,107, 2500,1250,625,312,156,156,  6,  0, 1, 1},
    '{2686,1199,600,300,107,107, 2500,1250,625,312,156,156,  6,  0, 0, 1},
    '{2500,1250,625,312,156,156, 2315,1386,700,384,111,103,  6,  0, 1, 1},
    '{2500,1200,625,256,209,209, 2500,1250,625,312,156,156, 12,  0, 1, 1},
    '{2500,1250,625,312,156,156, 2607,1250,625,312,103,102,  8,  0, 0, 1},
    '{2500,1250,625,312,156,156, 2500,1250,625,312,156,156,  7, 26, 1, 0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
  endtask

  task automatic put_run(input logic b, input int len);
    for (int k = 0; k < len; k++) put_bit(b);
  endtask

  // Close a block and check the report; dummy drives a valid 1 during the
  // synch and compare cycles, which must be dropped.
  task automatic close_block(input logic dummy, input int exp_runs, input int exp_long,
                             input string req);
    @(negedge clk);
    synch = 1'b1; bit_vld = dummy; bit_in = 1'b1;
    @(negedge clk);
    synch = 1'b0; bit_vld = dummy; bit_in = 1'b1;
    chk("R8", "ready in compare cycle", int'(ready), 0);
    @(negedge clk);
    bit_vld = 1'b0;
    chk("R8", "ready after compare", int'(ready), 1);
    chk(req, "runs_pass", int'(runs_pass), exp_runs);
    chk(req, "long_pass", int'(long_pass), exp_long);
    chk("R7", "all_pass", int'(all_pass), exp_runs & exp_long);
    @(negedge clk);
    chk("R8", "ready single pulse", int'(ready), 0);
    chk("R8", "runs_pass held", int'(runs_pass), exp_runs);
  endtask

  function automatic int run_len(input int r, input int pol, input int idx);
    int acc = 0;
    for (int b = 0; b < 6; b++) begin
      if (idx < acc + TBL[r][pol*6+b]) return (b < 5) ? b + 1 : TBL[r][12];
      acc += TBL[r][pol*6+b];
    end
    return 1;
  endfunction

  task automatic send_row(input int r);
    int total = 0;
    int first_top = 0;
    int len;
    for (int b = 0; b < 6; b++) total += TBL[r][b];
    for (int b = 0; b < 5; b++) first_top += TBL[r][b];
    for (int i = 0; i < total; i++) begin
      len = run_len(r, 0, i);
      if (i == first_top && TBL[r][13] != 0) len = TBL[r][13];
      put_run(1'b0, len);
      put_run(1'b1, run_len(r, 1, i));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 190000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; synch = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(ready), 0);
    chk("R1", "runs_pass after reset", int'(runs_pass), 0);
    chk("R1", "long_pass after reset", int'(long_pass), 0);
    chk("R1", "all_pass after reset", int'(all_pass), 0);

    // Table: row 0 top bin at length 7 (R3); rows 1-5 interval edges (R6);
    // row 3 last one-run of the top bin is open at synch (R4); row 6 long run (R5).
    for (int r = 0; r < NROWS; r++) begin
      send_row(r);
      close_block(1'b0, TBL[r][14], TBL[r][15], (r == 6) ? "R5" : ((r == 3) ? "R4" : "R6"));
    end

    // R10: invalid zeros inside a run of ones do not break it: 13+13 = 26 ones.
    put_run(1'b1, 13);
    repeat (3) begin @(negedge clk); bit_vld = 1'b0; bit_in = 1'b0; end
    put_run(1'b1, 13);
    close_block(1'b0, 0, 0, "R10");

    // R9: flag from the previous block is gone; 25 ones pass the long test (R5).
    // The valid ones in the synch and compare cycles must be dropped.
    put_run(1'b1, 25);
    close_block(1'b1, 0, 1, "R9");

    // R10: had the dropped ones leaked in, this run would reach 26 or 27.
    put_run(1'b1, 25);
    close_block(1'b0, 0, 1, "R10");

    // R5: a zero run of 30 fails the long test.
    put_run(1'b0, 30);
    close_block(1'b0, 0, 0, "R5");

    // R2: short alternating runs are too few to pass; long test passes.
    put_run(1'b0, 1); put_run(1'b1, 2); put_run(1'b0, 3); put_run(1'b1, 5);
    close_block(1'b0, 0, 1, "R2");

    // R9: empty block right after a report.
    close_block(1'b0, 0, 1, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule